// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Compare

An 8-bit up-counting timer that drives one compare channel and makes a single-slope PWM waveform. A prescaler turns the system clock into timer ticks. Each tick moves the counter one step from zero toward a fixed ceiling of 255. On the tick after the ceiling, the counter returns to zero, so the count forms a sawtooth. One PWM period lasts N × 256 clocks, where N is the selected divide ratio.

Software writes the compare value into a holding register. The holding register is copied into the active compare register only on the wrap tick, so a write in the middle of a period never changes the current period. The active compare value, the wrap event and a 2-bit output mode together decide the waveform. The modes are non-inverted PWM, inverted PWM, toggle-on-match (allowed only when a separate toggle-enable bit is set), or off.

There are two sticky flags, one for wrap and one for compare match. Each is cleared by a one-cycle clear pulse.

Top module: `fpwm_timer`

## Requirements
- R1: Each tick where `count` is below 255 raises `count` by exactly one. The tick where `count` equals 255 returns it to 0. Without a tick, `count` holds.
- R2: `clk_sel` sets the tick rate: 1 = every clock, 2 = every 8 clocks, 3 = every 64 clocks, 4 = every 256 clocks, 5 = every 1024 clocks. Codes 0, 6 and 7 give no ticks, and `count` stays frozen.
- R3: `ovf_flag` sets on the wrap tick (count 255 → 0) and stays set. A high `ovf_clr` clears it on the next edge. If a clear and a wrap come in the same cycle, the flag stays set.
- R4: `match_flag` sets on a tick where `count` equals the active compare value and stays set. A high `match_clr` clears it. If a clear and a match come in the same cycle, the flag stays set.
- R5: A write (`cmp_wr` high) loads only the holding register. The active compare value takes the holding value on the wrap tick, so the compare point of the period already under way does not change.
- R6: With `out_mode` = 2 and active compare C, `wave_out` is high while `count` is 0..C and low for the rest of the period. With C = 255 it stays high.
- R7: With `out_mode` = 3, `wave_out` is the complement of R6: low while `count` is 0..C and high otherwise. With C = 255 it stays low.
- R8: With `out_mode` = 1 and `toggle_en` high, `wave_out` changes level exactly once per period, on the compare match. With `out_mode` = 1 and `toggle_en` low, `wave_out` stays 0.
- R9: With `out_mode` = 0, `wave_out` stays 0 while the counter and `ovf_flag` keep working.
- R10: While `rst` is high, and right after it falls, `count` is 0, both flags are 0 and `wave_out` is 0.
- R11: In modes 2 and 3, `toggle_en` has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Tick rate select (R2 encoding) |
| out_mode | input | 2 | 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| toggle_en | input | 1 | Allows toggle behaviour in mode 1 |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| ovf_clr | input | 1 | Clears the wrap flag |
| match_clr | input | 1 | Clears the match flag |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| match_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Registered PWM waveform |

## Verification
The hardest case to reach is a compare write that lands inside a running period. Only the next period may show the new value. The bench first lets compare 100 settle. It then writes 10 while the count is near 50 and samples the output at count 80, where it must still be high. It then samples again after the wrap, at count 20 and count 5, where the new value must apply. The set-wins rules are reached in a similar way: the clear pulse is timed by watching `count` so that it lands on exactly the wrap tick or the match tick.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  // output mode codes
  localparam logic [1:0] OM_OFF    = 2'd0;
  localparam logic [1:0] OM_TOGGLE = 2'd1;
  localparam logic [1:0] OM_NONINV = 2'd2;
  localparam logic [1:0] OM_INV    = 2'd3;

  // tick-rate select codes
  localparam logic [2:0] PS_DIV1    = 3'd1;
  localparam logic [2:0] PS_DIV8    = 3'd2;
  localparam logic [2:0] PS_DIV64   = 3'd3;
  localparam logic [2:0] PS_DIV256  = 3'd4;
  localparam logic [2:0] PS_DIV1024 = 3'd5;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int SH_A = 3,
  parameter int SH_B = 6,
  parameter int SH_C = 8,
  parameter int SH_D = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  import fpwm_pkg::*;

  localparam int DW = SH_D;

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + 1'b1;
  end

  // true when the low sh bits of v are all ones
  function automatic logic low_full(input logic [DW-1:0] v, input int sh);
    logic [DW-1:0] m;
    m = (DW'(1) << sh) - DW'(1);
    return (v & m) == m;
  endfunction

  always_comb begin
    case (sel)
      PS_DIV1:    tick = 1'b1;
      PS_DIV8:    tick = low_full(div, SH_A);
      PS_DIV64:   tick = low_full(div, SH_B);
      PS_DIV256:  tick = low_full(div, SH_C);
      PS_DIV1024: tick = low_full(div, SH_D);
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int W   = 8,
  parameter int TOP = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] TOP_V = W'(TOP);

  assign wrap = tick && (count == TOP_V);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/fpwm_flag.sv
module fpwm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/fpwm_compare.sv
module fpwm_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] count,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   mode,
  input  logic         tog_en,
  output logic         hit,
  output logic [W-1:0] cmp_act,
  output logic         wave_out
);
  import fpwm_pkg::*;

  logic [W-1:0] cmp_hold;
  logic         oc_q;
  logic         oc_d;
  logic         pin_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_hold <= '0;
      cmp_act  <= '0;
    end else begin
      if (cmp_wr) cmp_hold <= cmp_wdata;
      if (wrap)   cmp_act  <= cmp_hold;
    end
  end

  assign hit    = tick && (count == cmp_act);
  assign pin_en = (mode == OM_NONINV) || (mode == OM_INV) ||
                  ((mode == OM_TOGGLE) && tog_en);

  always_comb begin
    oc_d = oc_q;
    if (hit) begin
      case (mode)
        OM_NONINV: oc_d = 1'b0;
        OM_INV:    oc_d = 1'b1;
        OM_TOGGLE: if (tog_en) oc_d = ~oc_q;
        default:   oc_d = oc_q;
      endcase
    end
    // the wrap action overrides a match on the same tick
    if (wrap) begin
      if (mode == OM_NONINV) oc_d = 1'b1;
      if (mode == OM_INV)    oc_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q     <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      oc_q     <= oc_d;
      wave_out <= pin_en ? oc_d : 1'b0;
    end
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int W    = 8,
  parameter int TOP  = 255,
  parameter int SH_A = 3,
  parameter int SH_B = 6,
  parameter int SH_C = 8,
  parameter int SH_D = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   clk_sel,
  input  logic [1:0]   out_mode,
  input  logic         toggle_en,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         ovf_clr,
  input  logic         match_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         match_flag,
  output logic         wave_out
);
  logic         tick_w;
  logic         wrap_w;
  logic         hit_w;
  logic [W-1:0] cmp_act_w;

  fpwm_prescaler #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C), .SH_D(SH_D)) u_pre (
    .clk(clk), .rst(rst), .sel(clk_sel), .tick(tick_w)
  );

  fpwm_counter #(.W(W), .TOP(TOP)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .count(count), .wrap(wrap_w)
  );

  fpwm_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick_w), .wrap(wrap_w), .count(count),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .mode(out_mode),
    .tog_en(toggle_en), .hit(hit_w), .cmp_act(cmp_act_w), .wave_out(wave_out)
  );

  fpwm_flag u_ovf (
    .clk(clk), .rst(rst), .set(wrap_w), .clr(ovf_clr), .flag(ovf_flag)
  );

  fpwm_flag u_match (
    .clk(clk), .rst(rst), .set(hit_w), .clr(match_clr), .flag(match_flag)
  );
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int W   = 8,
  parameter int TOP = 255
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_act,
  input logic [1:0]   out_mode,
  input logic         ovf_flag,
  input logic         match_flag,
  input logic         wave_out
);
  localparam logic [W-1:0] TOP_V = W'(TOP);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count != TOP_V) |=> (count == $past(count) + 1'b1));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count == TOP_V) |=> (count == '0));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count == TOP_V) |=> ovf_flag);

  // R4
  match_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count == cmp_act) |=> match_flag);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && count == TOP_V) |=> $stable(cmp_act));

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'd0) |=> !wave_out);
endmodule

bind fpwm_timer fpwm_timer_chk #(.W(W), .TOP(TOP)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .count(count), .cmp_act(cmp_act_w),
  .out_mode(out_mode), .ovf_flag(ovf_flag), .match_flag(match_flag),
  .wave_out(wave_out)
);

// File: tb/fpwm_timer_test.sv
module fpwm_timer_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] clk_sel;
  logic [1:0] out_mode;
  logic       toggle_en;
  logic       cmp_wr;
  logic [7:0] cmp_wdata;
  logic       ovf_clr;
  logic       match_clr;
  logic [7:0] count;
  logic       ovf_flag;
  logic       match_flag;
  logic       wave_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fpwm_timer uut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .out_mode(out_mode),
    .toggle_en(toggle_en), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ovf_clr(ovf_clr), .match_clr(match_clr), .count(count),
    .ovf_flag(ovf_flag), .match_flag(match_flag), .wave_out(wave_out)
  );

  // mode, toggle_en, compare, expected high samples (-1 skip), expected level changes
  localparam int NV = 12;
  localparam int TBL [NV][5] = '{
    '{2, 0, 100, 101, 2},
    '{2, 0,   0,   1, 2},
    '{2, 0, 255, 256, 0},
    '{3, 0, 100, 155, 2},
    '{3, 0,   0, 255, 2},
    '{3, 0, 255,   0, 0},
    '{3, 1, 254,   1, 2},
    '{2, 1, 200, 201, 2},
    '{1, 1,  40,  -1, 1},
    '{1, 1, 255,  -1, 1},
    '{1, 0,  40,   0, 0},
    '{0, 0,  40,   0, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_count(input int v);
    do @(negedge clk); while (int'(count) != v);
  endtask

  task automatic write_cmp(input int v);
    @(negedge clk);
    cmp_wr = 1'b1;
    cmp_wdata = 8'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic measure_div(input int sel, input int exp, input string tag);
    int v;
    int n;
    clk_sel = 3'(sel);
    v = int'(count);
    do @(negedge clk); while (int'(count) == v);
    v = int'(count);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (int'(count) == v);
    chk(tag, n, exp);
    chk({tag, " step"}, int'(count), (v + 1) % 256);
  endtask

  task automatic check_frozen(input int sel, input string tag);
    int v;
    clk_sel = 3'(sel);
    @(negedge clk);
    v = int'(count);
    repeat (1100) @(negedge clk);
    chk(tag, int'(count), v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; clk_sel = 3'd0; out_mode = 2'd0; toggle_en = 1'b0;
    cmp_wr = 1'b0; cmp_wdata = 8'd0; ovf_clr = 1'b0; match_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 count", int'(count), 0);
    chk("R10 ovf_flag", int'(ovf_flag), 0);
    chk("R10 match_flag", int'(match_flag), 0);
    chk("R10 wave_out", int'(wave_out), 0);

    clk_sel = 3'd1;
    // vector table: R6 R7 R8 R9 R11, R1 wrap, R3
    for (int i = 0; i < NV; i++) begin
      int high;
      int edges;
      int prev;
      out_mode = 2'(TBL[i][0]);
      toggle_en = TBL[i][1][0];
      write_cmp(TBL[i][2]);
      wait_count(0);
      wait_count(0);
      ovf_clr = 1'b1;
      prev = int'(wave_out);
      high = prev;
      edges = 0;
      for (int k = 1; k <= 256; k++) begin
        @(negedge clk);
        if (k == 1) begin
          ovf_clr = 1'b0;
          chk($sformatf("R3 clear row %0d", i), int'(ovf_flag), 0);
        end
        if (k == 255) chk($sformatf("R1 count top row %0d", i), int'(count), 255);
        if (k < 256 && wave_out) high++;
        if (int'(wave_out) != prev) edges++;
        prev = int'(wave_out);
      end
      chk($sformatf("R1 wrap row %0d", i), int'(count), 0);
      chk($sformatf("R3 R9 ovf set row %0d", i), int'(ovf_flag), 1);
      if (TBL[i][3] >= 0)
        chk($sformatf("R6 R7 R8 R9 R11 high row %0d", i), high, TBL[i][3]);
      chk($sformatf("R6 R7 R8 R9 R11 edges row %0d", i), edges, TBL[i][4]);
    end

    // R5 write mid-period only lands at the wrap
    out_mode = 2'd2; toggle_en = 1'b0;
    write_cmp(100);
    wait_count(0);
    wait_count(0);
    wait_count(50);
    write_cmp(10);
    wait_count(80);
    chk("R5 old compare kept", int'(wave_out), 1);
    wait_count(0);
    wait_count(5);
    chk("R5 new compare high", int'(wave_out), 1);
    wait_count(20);
    chk("R5 new compare low", int'(wave_out), 0);

    // R4 match flag, compare now 10
    wait_count(150);
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
    wait_count(160);
    chk("R4 cleared", int'(match_flag), 0);
    wait_count(9);
    chk("R4 before match", int'(match_flag), 0);
    @(negedge clk);
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
    chk("R4 set wins", int'(match_flag), 1);
    wait_count(20);
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
    chk("R4 clear alone", int'(match_flag), 0);

    // R3 set wins over clear at the wrap
    wait_count(255);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R3 set wins", int'(ovf_flag), 1);
    wait_count(5);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R3 clear alone", int'(ovf_flag), 0);
    chk("R3 sticky wait", int'(ovf_flag), 0);
    wait_count(0);
    chk("R3 set again", int'(ovf_flag), 1);

    // R2 tick rates and stop codes
    measure_div(1, 1, "R2 div1");
    measure_div(2, 8, "R2 div8");
    measure_div(3, 64, "R2 div64");
    measure_div(4, 256, "R2 div256");
    measure_div(5, 1024, "R2 div1024");
    check_frozen(0, "R2 stop code0");
    check_frozen(6, "R2 stop code6");
    check_frozen(7, "R2 stop code7");

    // R10 reset while running
    clk_sel = 3'd1;
    out_mode = 2'd2;
    wait_count(3);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid count", int'(count), 0);
    chk("R10 mid wave", int'(wave_out), 0);
    chk("R10 mid ovf", int'(ovf_flag), 0);
    chk("R10 mid match", int'(match_flag), 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule